// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a microcontroller bus and a flash array. It watches every write cycle sent to the flash region and decodes the multi-write unlock and command protocol. Recognised sequences turn into single-cycle requests to the array: program a byte, erase a set of sectors or the whole block, and suspend or resume an erase. It also steers the read path to array data, an identification byte or a sector-protect status byte.

A write is framed by the active-low strobe. The full address and the sector selects are captured when the strobe falls. The data is taken, and the write is decoded, when the strobe rises. Only the low twelve address bits take part in decoding. Sector-erase commands open an accumulation window of `ACC_WIN` clock cycles, counted from the most recent sector-add write. Each further sector-add write inside the window ORs in its sector and restarts the window. The array reports completion with a one-cycle done pulse, and an error with a level flag.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The writes AAh@555h, 55h@AAAh, A0h@555h followed by one data write give one `prog_req` pulse. `prog_addr` carries the full address latched at the strobe's falling edge and `prog_data` the data at its rising edge. Address bits above bit 11 never affect decoding.
- R2: A write whose address or data does not match the expected step aborts the sequence, and no request is issued.
- R3: The writes AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, 10h@555h give one `erase_req` with `erase_bulk`=1 and every bit of `erase_mask` set.
- R4: The same five writes followed by 30h give no immediate request. Each 30h write ORs the active `sect_sel` bits into the mask and restarts the window. `ACC_WIN` cycles after the last such write, one `erase_req` follows with `erase_bulk`=0 and the accumulated mask.
- R5: After 90h as the third write, `rd_sel` is 1 (ID byte) for addresses with bits [1:0]=01. It is 2 (protect status) for bits [1:0]=10 with any sector select active. Otherwise it is 0 (array). A write of F0h at any address returns `rd_sel` to 0.
- R6: B0h at any address gives `susp_pulse`, but only while a sector erase is outstanding. An outstanding erase is one requested and not yet acknowledged by `arr_done`. A B0h write in the same cycle as `arr_done`, or at any other time, gives no pulse.
- R7: 30h at any address while suspended gives `resume_pulse`. 30h at other times gives none.
- R8: While suspended, a program to a sector outside the erase mask is issued. A program to a sector inside the mask is dropped.
- R9: After 20h as the third write, each pair of writes A0h at any address followed by data gives a program. The writes 90h then 00h leave this mode, after which A0h plus data gives nothing.
- R10: While `arr_busy` is high, or a program or erase is outstanding, every write other than F0h and B0h is ignored.
- R11: After `arr_err` has been high, every write other than F0h is ignored until an F0h write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr_n | input | 1 | Active-low write strobe |
| sect_sel | input | NSECT | Decoded sector selects, active high |
| arr_busy | input | 1 | Array is busy |
| arr_done | input | 1 | One-cycle completion of the outstanding operation |
| arr_err | input | 1 | Array error flag |
| prog_req | output | 1 | Program request pulse |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data |
| erase_req | output | 1 | Erase request pulse |
| erase_bulk | output | 1 | Erase covers the whole block |
| erase_mask | output | NSECT | Sectors to erase |
| susp_pulse | output | 1 | Erase suspend pulse |
| resume_pulse | output | 1 | Erase resume pulse |
| rd_sel | output | 2 | Read source: 0 array, 1 ID, 2 protect |

## Verification
A suspend write and the array's completion of the sector erase can land in the same cycle. The bench raises the strobe of a B0h write and drives `arr_done` in that same cycle. Completion must win, so no suspend pulse appears. A second B0h write must then also give no pulse, because the erase is no longer outstanding.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3, S_ACC,
        S_AUTO, S_BYP, S_BYP_PROG, S_BYP_EXIT
    } seq_e;

    typedef enum logic [1:0] {OP_NONE, OP_SERASE, OP_BULK, OP_SUSP} op_e;

    localparam logic [1:0] RD_ARRAY = 2'd0;
    localparam logic [1:0] RD_ID    = 2'd1;
    localparam logic [1:0] RD_PROT  = 2'd2;

    localparam logic [7:0] K_UNLK1 = 8'hAA;
    localparam logic [7:0] K_UNLK2 = 8'h55;
    localparam logic [7:0] K_AUTO  = 8'h90;
    localparam logic [7:0] K_PROG  = 8'hA0;
    localparam logic [7:0] K_ERASE = 8'h80;
    localparam logic [7:0] K_BYP   = 8'h20;
    localparam logic [7:0] K_SECT  = 8'h30;
    localparam logic [7:0] K_BULK  = 8'h10;
    localparam logic [7:0] K_SUSP  = 8'hB0;
    localparam logic [7:0] K_RST   = 8'hF0;
    localparam logic [7:0] K_BYPX  = 8'h00;
endpackage

// File: rtl/fcd_strobe.sv
module fcd_strobe #(
    parameter int ADDR_W = 16,
    parameter int NSECT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSECT-1:0]  cs,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [NSECT-1:0]  lat_cs,
    output logic              wr_evt
);
    logic              wr_d, wr_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [NSECT-1:0]  cs_d, cs_q;

    always_comb begin
        wr_d   = wr_n;
        addr_d = addr_q;
        cs_d   = cs_q;
        if (wr_q && !wr_n) begin
            addr_d = addr;
            cs_d   = cs;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b1;
            addr_q <= '0;
            cs_q   <= '0;
        end else begin
            wr_q   <= wr_d;
            addr_q <= addr_d;
            cs_q   <= cs_d;
        end
    end

    assign wr_evt   = !wr_q && wr_n;
    assign lat_addr = addr_q;
    assign lat_cs   = cs_q;
endmodule

// File: rtl/fcd_acc_timer.sv
module fcd_acc_timer #(
    parameter int WIN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(WIN + 1);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CW'(WIN - 1);
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && !load && (cnt_q == '0);

    // R4
    win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == CW'(WIN - 1)));
endmodule

// File: rtl/fcd_read_sel.sv
module fcd_read_sel (
    input  logic       auto_mode,
    input  logic [1:0] addr_lo,
    input  logic       cs_any,
    output logic [1:0] sel
);
    import fcd_pkg::*;
    always_comb begin
        sel = RD_ARRAY;
        if (auto_mode) begin
            if (addr_lo == 2'b01)
                sel = RD_ID;
            else if (addr_lo == 2'b10 && cs_any)
                sel = RD_PROT;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W  = 16,
    parameter int DEC_W   = 12,
    parameter int NSECT   = 8,
    parameter int ACC_WIN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr_n,
    input  logic [NSECT-1:0]  sect_sel,
    input  logic              arr_busy,
    input  logic              arr_done,
    input  logic              arr_err,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_req,
    output logic              erase_bulk,
    output logic [NSECT-1:0]  erase_mask,
    output logic              susp_pulse,
    output logic              resume_pulse,
    output logic [1:0]        rd_sel
);
    import fcd_pkg::*;

    localparam logic [DEC_W-1:0] ADR_A = DEC_W'(12'h555);
    localparam logic [DEC_W-1:0] ADR_B = DEC_W'(12'hAAA);

    typedef struct packed {
        seq_e              seq;
        op_e               op;
        logic              pgm_busy;
        logic              err;
        logic [NSECT-1:0]  mask;
        logic              prog_req;
        logic [ADDR_W-1:0] prog_addr;
        logic [7:0]        prog_data;
        logic              erase_req;
        logic              bulk;
        logic              susp;
        logic              resume;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] lat_addr;
    logic [NSECT-1:0]  lat_cs;
    logic              wr_evt, tmr_load, tmr_run, tmr_exp;
    logic [DEC_W-1:0]  lo;
    logic [7:0]        wd;
    logic              busy, in_byp, blocked;

    fcd_strobe #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_strobe (
        .clk(clk), .rst_n(rst_n), .wr_n(bus_wr_n), .addr(bus_addr),
        .cs(sect_sel), .lat_addr(lat_addr), .lat_cs(lat_cs), .wr_evt(wr_evt));

    fcd_acc_timer #(.WIN(ACC_WIN)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
        .expire(tmr_exp));

    fcd_read_sel u_rdsel (
        .auto_mode(st_q.seq == S_AUTO), .addr_lo(bus_addr[1:0]),
        .cs_any(|sect_sel), .sel(rd_sel));

    assign lo      = lat_addr[DEC_W-1:0];
    assign wd      = bus_wdata;
    assign busy    = arr_busy || st_q.pgm_busy ||
                     st_q.op == OP_SERASE || st_q.op == OP_BULK;
    assign in_byp  = st_q.seq == S_BYP || st_q.seq == S_BYP_PROG ||
                     st_q.seq == S_BYP_EXIT;
    assign blocked = (st_q.op == OP_SUSP) && |(lat_cs & st_q.mask);
    assign tmr_run = (st_q.seq == S_ACC) && !wr_evt;

    always_comb begin
        st_d           = st_q;
        st_d.prog_req  = 1'b0;
        st_d.erase_req = 1'b0;
        st_d.susp      = 1'b0;
        st_d.resume    = 1'b0;
        tmr_load       = 1'b0;

        if (arr_done) begin
            if (st_q.pgm_busy)
                st_d.pgm_busy = 1'b0;
            else if (st_q.op == OP_SERASE || st_q.op == OP_BULK)
                st_d.op = OP_NONE;
        end

        if (tmr_exp) begin
            st_d.erase_req = 1'b1;
            st_d.bulk      = 1'b0;
            st_d.op        = OP_SERASE;
            st_d.seq       = S_IDLE;
        end

        if (wr_evt) begin
            if (wd == K_RST) begin
                st_d.err = 1'b0;
                st_d.seq = in_byp ? S_BYP : S_IDLE;
            end else if (st_q.err) begin
                st_d.seq = st_q.seq;
            end else if (wd == K_SUSP && st_q.op == OP_SERASE && !arr_done) begin
                st_d.op   = OP_SUSP;
                st_d.susp = 1'b1;
            end else if (!busy) begin
                unique case (st_q.seq)
                    S_IDLE: begin
                        if (st_q.op == OP_SUSP && wd == K_SECT) begin
                            st_d.op     = OP_SERASE;
                            st_d.resume = 1'b1;
                        end else if (lo == ADR_A && wd == K_UNLK1)
                            st_d.seq = S_U1;
                    end
                    S_U1: st_d.seq = (lo == ADR_B && wd == K_UNLK2) ? S_U2 : S_IDLE;
                    S_U2: begin
                        st_d.seq = S_IDLE;
                        if (lo == ADR_A) begin
                            if (wd == K_AUTO)      st_d.seq = S_AUTO;
                            else if (wd == K_PROG) st_d.seq = S_PROG;
                            else if (wd == K_ERASE && st_q.op != OP_SUSP) st_d.seq = S_E1;
                            else if (wd == K_BYP && st_q.op != OP_SUSP)   st_d.seq = S_BYP;
                        end
                    end
                    S_PROG, S_BYP_PROG: begin
                        st_d.seq = (st_q.seq == S_PROG) ? S_IDLE : S_BYP;
                        if (!blocked) begin
                            st_d.prog_req  = 1'b1;
                            st_d.prog_addr = lat_addr;
                            st_d.prog_data = wd;
                            st_d.pgm_busy  = 1'b1;
                        end
                    end
                    S_E1: st_d.seq = (lo == ADR_A && wd == K_UNLK1) ? S_E2 : S_IDLE;
                    S_E2: st_d.seq = (lo == ADR_B && wd == K_UNLK2) ? S_E3 : S_IDLE;
                    S_E3: begin
                        st_d.seq = S_IDLE;
                        if (wd == K_SECT) begin
                            st_d.seq  = S_ACC;
                            st_d.mask = lat_cs;
                            tmr_load  = 1'b1;
                        end else if (wd == K_BULK && lo == ADR_A) begin
                            st_d.erase_req = 1'b1;
                            st_d.bulk      = 1'b1;
                            st_d.mask      = '1;
                            st_d.op        = OP_BULK;
                        end
                    end
                    S_ACC: begin
                        if (wd == K_SECT) begin
                            st_d.mask = st_q.mask | lat_cs;
                            tmr_load  = 1'b1;
                        end else
                            st_d.seq = S_IDLE;
                    end
                    S_AUTO: st_d.seq = S_AUTO;
                    S_BYP: begin
                        if (wd == K_PROG)      st_d.seq = S_BYP_PROG;
                        else if (wd == K_AUTO) st_d.seq = S_BYP_EXIT;
                    end
                    S_BYP_EXIT: st_d.seq = (wd == K_BYPX) ? S_IDLE : S_BYP;
                    default: st_d.seq = S_IDLE;
                endcase
            end
        end

        if (arr_err) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.seq <= S_IDLE;
            st_q.op  <= OP_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_req     = st_q.prog_req;
    assign prog_addr    = st_q.prog_addr;
    assign prog_data    = st_q.prog_data;
    assign erase_req    = st_q.erase_req;
    assign erase_bulk   = st_q.bulk;
    assign erase_mask   = st_q.mask;
    assign susp_pulse   = st_q.susp;
    assign resume_pulse = st_q.resume;

    // R3
    bulk_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_bulk) |-> (&erase_mask));
    // R4
    sect_from_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_bulk) |-> ($past(st_q.seq) == S_ACC));
    // R6
    susp_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pulse |-> ($past(st_q.op) == OP_SERASE && st_q.op == OP_SUSP));
    // R7
    resume_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> ($past(st_q.op) == OP_SUSP));
    // R10
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req, susp_pulse, resume_pulse}));
    // R11
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !$past(st_q.err));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    localparam int AW = 16, NS = 4, WIN = 12;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_wr_n = 1;
    logic [NS-1:0] sect_sel = '0;
    logic arr_busy = 0, arr_done = 0, arr_err = 0;
    logic prog_req, erase_req, erase_bulk, susp_pulse, resume_pulse;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data;
    logic [NS-1:0] erase_mask;
    logic [1:0]    rd_sel;

    int errors = 0, checks = 0;
    int n_prog = 0, n_erase = 0, n_susp = 0, n_res = 0;
    logic [AW-1:0] l_pa;
    logic [7:0]    l_pd;
    logic [NS-1:0] l_mask;
    logic          l_bulk;
    bit            finished = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DEC_W(12), .NSECT(NS), .ACC_WIN(WIN)) u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr_n(bus_wr_n), .sect_sel(sect_sel), .arr_busy(arr_busy),
        .arr_done(arr_done), .arr_err(arr_err), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_data(prog_data), .erase_req(erase_req),
        .erase_bulk(erase_bulk), .erase_mask(erase_mask), .susp_pulse(susp_pulse),
        .resume_pulse(resume_pulse), .rd_sel(rd_sel));

    always @(posedge clk) begin
        if (prog_req)     begin n_prog++; l_pa = prog_addr; l_pd = prog_data; end
        if (erase_req)    begin n_erase++; l_mask = erase_mask; l_bulk = erase_bulk; end
        if (susp_pulse)   n_susp++;
        if (resume_pulse) n_res++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [NS-1:0] cs);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; sect_sel = cs; bus_wr_n = 0;
        @(negedge clk); bus_wr_n = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr_with_done(input logic [7:0] d);
        @(negedge clk);
        bus_addr = '0; bus_wdata = d; sect_sel = '0; bus_wr_n = 0;
        @(negedge clk); bus_wr_n = 1; arr_done = 1;
        @(negedge clk); arr_done = 0;
        @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk); arr_done = 1;
        @(negedge clk); arr_done = 0;
        @(negedge clk);
    endtask

    task automatic unlock3(input logic [7:0] c);
        wr(16'h0555, 8'hAA, '0);
        wr(16'h0AAA, 8'h55, '0);
        wr(16'h0555, c, '0);
    endtask

    task automatic erase_pre();
        unlock3(8'h80);
        wr(16'h0555, 8'hAA, '0);
        wr(16'h0AAA, 8'h55, '0);
    endtask

    task automatic rd_probe(input logic [AW-1:0] a, input logic [NS-1:0] cs, input int exp, input string tag);
        @(negedge clk);
        bus_addr = a; sect_sel = cs;
        #1 chk(rd_sel == 2'(exp), tag, rd_sel, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int p0, e0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!prog_req && !erase_req && !susp_pulse && !resume_pulse && rd_sel == 0,
            "reset R1", {prog_req, erase_req, susp_pulse, resume_pulse}, 0);

        // R1 R2 R5 R9: sweep of every third-cycle byte, high address bits varied
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb = 8'(c);
            logic [AW-1:0] hi = {cb[3:0], 12'h000};
            p0 = n_prog;
            wr(hi | 16'h0555, 8'hAA, '0);
            wr(hi | 16'h0AAA, 8'h55, '0);
            wr(hi | 16'h0555, cb, '0);
            wr(16'hF123, cb ^ 8'h3C, 4'b0010);
            chk(n_prog - p0 == ((cb == 8'hA0) ? 1 : 0), "R1/R2 sweep prog count", n_prog - p0, cb);
            if (cb == 8'hA0) begin
                chk(l_pa == 16'hF123 && l_pd == 8'h9C, "R1 program addr/data", {l_pa, l_pd}, 24'hF1239C);
                done_pulse();
            end
            if (cb == 8'h90) begin
                rd_probe(16'h3001, '0, 1, "R5 id select");
                rd_probe(16'h3002, 4'b0100, 2, "R5 protect select");
                rd_probe(16'h3002, '0, 0, "R5 protect needs select");
            end
            if (cb == 8'h20) begin
                wr(16'h0000, 8'h90, '0);
                wr(16'h0000, 8'h00, '0);
            end
            wr(16'h0123, 8'hF0, '0);
            rd_probe(16'h0001, '0, 0, "R5 F0 back to array");
        end

        // R2 mismatched address at second and third step
        p0 = n_prog;
        wr(16'h0555, 8'hAA, '0); wr(16'h0AAB, 8'h55, '0); wr(16'h0555, 8'hA0, '0); wr(16'h0100, 8'h11, '0);
        wr(16'h0555, 8'hAA, '0); wr(16'h0AAA, 8'h55, '0); wr(16'h0554, 8'hA0, '0); wr(16'h0100, 8'h11, '0);
        chk(n_prog == p0, "R2 address mismatch", n_prog - p0, 0);

        // R3 bulk erase
        e0 = n_erase;
        erase_pre();
        wr(16'h0555, 8'h10, '0);
        chk(n_erase - e0 == 1 && l_bulk && l_mask == '1, "R3 bulk erase", {l_bulk, l_mask}, 5'h1F);
        done_pulse();

        // R4 accumulation sweep over sector counts
        for (int n = 1; n <= NS; n++) begin
            e0 = n_erase;
            erase_pre();
            wr(16'h0000, 8'h30, 4'b0001);
            for (int k = 1; k < n; k++) wr(16'h0000, 8'h30, NS'(1 << k));
            chk(n_erase == e0, "R4 no erase inside window", n_erase - e0, 0);
            repeat (WIN + 4) @(negedge clk);
            chk(n_erase - e0 == 1 && !l_bulk && l_mask == NS'((1 << n) - 1),
                "R4 accumulated mask", l_mask, (1 << n) - 1);
            done_pulse();
        end

        // R6 R7 R8 suspend, program while suspended, resume
        e0 = n_erase;
        erase_pre();
        wr(16'h0000, 8'h30, 4'b0001);
        repeat (WIN + 4) @(negedge clk);
        chk(n_erase - e0 == 1, "R4 single sector erase", n_erase - e0, 1);
        p0 = n_prog;
        wr(16'h0000, 8'hA5, '0);
        chk(n_prog == p0 && n_susp == 0, "R10 write ignored while erasing", n_prog - p0, 0);
        wr(16'h0321, 8'hB0, '0);
        chk(n_susp == 1, "R6 suspend pulse", n_susp, 1);
        unlock3(8'hA0); wr(16'h0010, 8'h77, 4'b0001);
        chk(n_prog == p0, "R8 program in erasing sector dropped", n_prog - p0, 0);
        unlock3(8'hA0); wr(16'h0020, 8'h66, 4'b0100);
        chk(n_prog - p0 == 1 && l_pd == 8'h66, "R8 program other sector", n_prog - p0, 1);
        done_pulse();
        wr(16'h0777, 8'h30, '0);
        chk(n_res == 1, "R7 resume pulse", n_res, 1);
        done_pulse();
        wr(16'h0000, 8'hB0, '0);
        chk(n_susp == 1, "R6 no suspend when idle", n_susp, 1);
        wr(16'h0000, 8'h30, '0);
        chk(n_res == 1, "R7 no resume when not suspended", n_res, 1);

        // R6 suspend and completion in the same cycle
        erase_pre();
        wr(16'h0000, 8'h30, 4'b0010);
        repeat (WIN + 4) @(negedge clk);
        wr_with_done(8'hB0);
        chk(n_susp == 1, "R6 done wins over suspend", n_susp, 1);
        wr(16'h0000, 8'hB0, '0);
        chk(n_susp == 1, "R6 no suspend after done", n_susp, 1);

        // R10 busy input
        p0 = n_prog;
        arr_busy = 1;
        unlock3(8'hA0); wr(16'h0040, 8'h12, '0);
        chk(n_prog == p0, "R10 busy blocks program", n_prog - p0, 0);
        arr_busy = 0;
        wr(16'h0000, 8'hF0, '0);
        unlock3(8'hA0); wr(16'h0040, 8'h12, '0);
        chk(n_prog - p0 == 1, "R10 program after busy", n_prog - p0, 1);
        done_pulse();

        // R11 error flag
        p0 = n_prog;
        @(negedge clk); arr_err = 1; @(negedge clk); arr_err = 0;
        unlock3(8'hA0); wr(16'h0050, 8'h34, '0);
        chk(n_prog == p0, "R11 error blocks program", n_prog - p0, 0);
        wr(16'h0ABC, 8'hF0, '0);
        unlock3(8'hA0); wr(16'h0050, 8'h34, '0);
        chk(n_prog - p0 == 1, "R11 program after F0", n_prog - p0, 1);
        done_pulse();

        // R9 bypass programs and exit
        p0 = n_prog;
        unlock3(8'h20);
        for (int i = 0; i < 4; i++) begin
            wr(16'(i * 16'h0111), 8'hA0, '0);
            wr(16'(16'h0200 + i), 8'(8'h40 + i), '0);
            chk(n_prog - p0 == i + 1 && l_pd == 8'(8'h40 + i), "R9 bypass program", l_pd, 8'h40 + i);
            done_pulse();
        end
        wr(16'h0000, 8'h90, '0);
        wr(16'h0000, 8'h00, '0);
        wr(16'h0000, 8'hA0, '0);
        wr(16'h0300, 8'h55, '0);
        chk(n_prog - p0 == 4, "R9 bypass exited", n_prog - p0, 4);

        finish_run();
    end
endmodule